// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host access to a network controller's packet memory through a single data port. The register file loads a current address and a remaining byte count. Each access on the port then moves 1, 2 or 4 bytes between the port and packet memory, and the engine steps the address and the count on its own. When the count runs out, the block raises a sticky completion flag, which the register file can clear.

Packet memory has two valid windows: a small low window at the bottom of the address space and a larger high window for packet buffers. Bytes outside these windows read as all-ones, and writes to them are dropped. The address follows a receive ring given as two page numbers (page × 256). When the address steps onto the ring stop address, it reloads the ring start address. Storage is four byte-wide banks interleaved on address bits [1:0], so one access of any size touches each bank at most once.

Top module: `rdma_port_engine`

## Requirements
- R1: After a synchronous reset, `cur_addr` is 0, `cur_cnt` is 0, `dma_done` is 0 and `acc_rvalid` is 0.
- R2: `addr_ld` loads `cur_addr` and `cnt_ld` loads `cur_cnt`. Each load takes effect at the next clock edge and wins over an access in the same cycle. The memory access itself still uses the old address.
- R3: `acc_size` encodes the access length: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 and 2'b11 are 4 bytes. Accesses of 2 and 4 bytes use the current address with bit 0 forced to 0 as their base.
- R4: The data is little-endian. Byte k of the access lives at base+k and maps to data bits [8k+7:8k]. Read data bytes at or above the access length are 0.
- R5: A read accepted at one clock edge puts `acc_rvalid` high and valid data on `acc_rdata` during the following cycle. In every other cycle, `acc_rvalid` is 0 and `acc_rdata` is 0.
- R6: A byte address is valid if it is below LO_SIZE (32), or if it lies in [HI_BASE, HI_BASE+HI_SIZE) (defaults 16384 and 4096). This is checked per byte. Invalid bytes read as 8'hFF, and writes to them are discarded.
- R7: Each performed access adds the access length to the original, unaligned address, modulo 2^16. If the sum equals `ring_stop_pg`×256, the address becomes `ring_start_pg`×256 instead.
- R8: Each performed access checks the count. If the count is at most the access length, the count becomes 0 and `dma_done` is set. Otherwise the count drops by the access length.
- R9: A data-port write while `cur_cnt` is 0 is ignored. Memory, address, count and `dma_done` all stay unchanged.
- R10: A `cmd_issue` pulse while `cur_cnt` is 0 sets `dma_done`. With a nonzero count it has no effect.
- R11: `done_clr` clears `dma_done`. A set in the same cycle takes priority.
- R12: A read while `cur_cnt` is 0 is still performed. The address advances, the count stays 0 and `dma_done` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_ld | input | 1 | Load current address |
| addr_ld_val | input | 16 | Address to load |
| cnt_ld | input | 1 | Load remaining byte count |
| cnt_ld_val | input | 16 | Count to load |
| ring_start_pg | input | 8 | Receive ring first page |
| ring_stop_pg | input | 8 | Receive ring end page (exclusive) |
| cmd_issue | input | 1 | Remote DMA command issued |
| done_clr | input | 1 | Clear the completion flag |
| acc_req | input | 1 | Data port access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access length code |
| acc_wdata | input | 32 | Write data, little-endian |
| acc_rdata | output | 32 | Read data, little-endian |
| acc_rvalid | output | 1 | Read data valid |
| cur_addr | output | 16 | Current remote address |
| cur_cnt | output | 16 | Remaining byte count |
| dma_done | output | 1 | DMA completion flag |

## Verification
The assertions assume that reset is held from time zero until the first clocks, and that `cmd_issue` and accesses are the only events that can set the flag. The wrap check also assumes that the ring start and stop pages differ whenever an access is performed. The stimulus changes the ring pages only between transfers and always keeps start below stop. The random addresses cluster around the window edges, the ring stop and the low window, so that single bytes straddle validity boundaries and the wrap occurs repeatedly.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  function automatic logic [2:0] size_len(input logic [1:0] code);
    case (acc_size_e'(code))
      SZ_BYTE: size_len = 3'd1;
      SZ_HALF: size_len = 3'd2;
      default: size_len = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rdma_lane_map.sv
module rdma_lane_map #(
  parameter int AW      = 16,
  parameter int LO_SIZE = 32,
  parameter int HI_BASE = 16384,
  parameter int HI_SIZE = 4096,
  parameter int RW      = 11
) (
  input  logic [AW-1:0]                        base,
  input  logic [2:0]                           len,
  output logic [rdma_pkg::LANES-1:0]           en,
  output logic [rdma_pkg::LANES-1:0]           ok,
  output logic [rdma_pkg::LANES-1:0][1:0]      lane,
  output logic [rdma_pkg::LANES-1:0][RW-1:0]   row
);
  localparam logic [AW:0] LO_LIM = (AW+1)'(LO_SIZE);
  localparam logic [AW:0] HI_LO  = (AW+1)'(HI_BASE);
  localparam logic [AW:0] HI_LIM = (AW+1)'(HI_BASE + HI_SIZE);
  localparam logic [RW-1:0] HI_ROW0 = RW'(LO_SIZE / 4);

  for (genvar b = 0; b < rdma_pkg::LANES; b++) begin : g_bank
    logic [1:0]  k;
    logic [AW:0] ak;
    logic [AW:0] off;
    always_comb begin
      k       = 2'(b) - base[1:0];
      ak      = {1'b0, base + AW'(k)};
      off     = ak - HI_LO;
      lane[b] = k;
      en[b]   = {1'b0, k} < len;
      ok[b]   = (ak < LO_LIM) || ((ak >= HI_LO) && (ak < HI_LIM));
      if (ak < LO_LIM) row[b] = RW'(ak >> 2);
      else             row[b] = RW'(off >> 2) + HI_ROW0;
    end
  end
endmodule

// File: rtl/rdma_byte_bank.sv
module rdma_byte_bank #(
  parameter int DEPTH = 1032,
  parameter int RW    = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
    rdata <= mem[row];
  end
endmodule

// File: rtl/rdma_addr_ctrl.sv
module rdma_addr_ctrl #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_ld_val,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_ld_val,
  input  logic [AW-9:0] start_pg,
  input  logic [AW-9:0] stop_pg,
  input  logic          cmd_issue,
  input  logic          done_clr,
  input  logic          fire,
  input  logic [2:0]    len,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          done_q
);
  logic [AW-1:0] stop_addr, start_addr, step_addr, next_addr;
  logic          last_chunk, set_done;

  always_comb begin
    stop_addr  = {stop_pg, 8'h00};
    start_addr = {start_pg, 8'h00};
    step_addr  = addr_q + AW'(len);
    next_addr  = (step_addr == stop_addr) ? start_addr : step_addr;
    last_chunk = cnt_q <= CW'(len);
    set_done   = (fire && last_chunk) || (cmd_issue && (cnt_q == '0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (addr_ld)   addr_q <= addr_ld_val;
      else if (fire) addr_q <= next_addr;
      if (cnt_ld)    cnt_q <= cnt_ld_val;
      else if (fire) cnt_q <= last_chunk ? '0 : cnt_q - CW'(len);
      if (set_done)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  // R8
  cnt_down_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cnt_ld) |-> (cnt_q <= $past(cnt_q)));

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(cmd_issue || fire));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fire && !addr_ld) && (start_pg != stop_pg) && $stable(stop_pg))
      |-> (addr_q != stop_addr));
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int LO_SIZE = 32,
  parameter int HI_BASE = 16384,
  parameter int HI_SIZE = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_ld,
  input  logic [15:0]   addr_ld_val,
  input  logic          cnt_ld,
  input  logic [15:0]   cnt_ld_val,
  input  logic [7:0]    ring_start_pg,
  input  logic [7:0]    ring_stop_pg,
  input  logic          cmd_issue,
  input  logic          done_clr,
  input  logic          acc_req,
  input  logic          acc_wr,
  input  logic [1:0]    acc_size,
  input  logic [31:0]   acc_wdata,
  output logic [31:0]   acc_rdata,
  output logic          acc_rvalid,
  output logic [15:0]   cur_addr,
  output logic [15:0]   cur_cnt,
  output logic          dma_done
);
  import rdma_pkg::*;

  localparam int DEPTH = (LO_SIZE + HI_SIZE) / 4;
  localparam int RW    = $clog2(DEPTH);

  logic [2:0]               len;
  logic                     fire;
  logic [AW-1:0]            addr_q, base;
  logic [CW-1:0]            cnt_q;
  logic                     done_q;
  logic [LANES-1:0]         en, ok;
  logic [LANES-1:0][1:0]    lane;
  logic [LANES-1:0][RW-1:0] row;
  logic [LANES-1:0][7:0]    bank_q;
  logic [LANES-1:0]         en_q, ok_q;
  logic [LANES-1:0][1:0]    lane_q;
  logic                     rvalid_q;
  logic [31:0]              rdata_c;

  always_comb begin
    len  = size_len(acc_size);
    fire = acc_req && !(acc_wr && (cnt_q == '0));
    base = (len > 3'd1) ? {addr_q[AW-1:1], 1'b0} : addr_q;
  end

  rdma_addr_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
    .start_pg(ring_start_pg), .stop_pg(ring_stop_pg),
    .cmd_issue(cmd_issue), .done_clr(done_clr),
    .fire(fire), .len(len),
    .addr_q(addr_q), .cnt_q(cnt_q), .done_q(done_q)
  );

  rdma_lane_map #(.AW(AW), .LO_SIZE(LO_SIZE), .HI_BASE(HI_BASE),
                  .HI_SIZE(HI_SIZE), .RW(RW)) u_map (
    .base(base), .len(len), .en(en), .ok(ok), .lane(lane), .row(row)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_mem
    rdma_byte_bank #(.DEPTH(DEPTH), .RW(RW)) u_bank (
      .clk(clk),
      .we(fire && acc_wr && en[b] && ok[b]),
      .row(row[b]),
      .wdata(acc_wdata[8*lane[b] +: 8]),
      .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      en_q     <= '0;
      ok_q     <= '0;
      lane_q   <= '0;
    end else begin
      rvalid_q <= fire && !acc_wr;
      en_q     <= en;
      ok_q     <= ok;
      lane_q   <= lane;
    end
  end

  always_comb begin
    rdata_c = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int b = 0; b < LANES; b++) begin
        if (en_q[b] && (lane_q[b] == 2'(k)))
          rdata_c[8*k +: 8] = ok_q[b] ? bank_q[b] : 8'hFF;
      end
    end
  end

  assign acc_rdata  = rvalid_q ? rdata_c : 32'h0;
  assign acc_rvalid = rvalid_q;
  assign cur_addr   = addr_q;
  assign cur_cnt    = cnt_q;
  assign dma_done   = done_q;

  // R5
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_wr) |=> acc_rvalid);

  // R9
  ign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_wr && (cur_cnt == 16'h0) && !addr_ld && !cnt_ld)
      |=> ($stable(cur_addr) && (cur_cnt == 16'h0)));

  // R4
  narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_wr && (acc_size == 2'b00)) |=> (acc_rdata[31:8] == 24'h0));
endmodule

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;
  localparam int LO  = 32;
  localparam int HB  = 16384;
  localparam int HS  = 4096;
  localparam int MSZ = LO + HS;

  logic clk = 0, rst = 1;
  logic addr_ld = 0, cnt_ld = 0, cmd_issue = 0, done_clr = 0;
  logic [15:0] addr_ld_val = 0, cnt_ld_val = 0;
  logic [7:0] ring_start_pg = 0, ring_stop_pg = 0;
  logic acc_req = 0, acc_wr = 0;
  logic [1:0] acc_size = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic acc_rvalid, dma_done;
  logic [15:0] cur_addr, cur_cnt;

  rdma_port_engine uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int m_addr = 0, m_cnt = 0;
  bit m_done = 0;
  logic [7:0] mdl [MSZ];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit win(int a);
    return (a < LO) || (a >= HB && a < HB + HS);
  endfunction

  function automatic int idx(int a);
    return (a < LO) ? a : a - HB + LO;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_state(string tag);
    chk({tag, " addr"}, 32'(cur_addr), 32'(m_addr));
    chk({tag, " cnt"}, 32'(cur_cnt), 32'(m_cnt));
    chk({tag, " done"}, 32'(dma_done), 32'(m_done));
  endtask

  task automatic load(int a, int c, string tag);
    addr_ld = 1; addr_ld_val = 16'(a);
    cnt_ld = 1;  cnt_ld_val = 16'(c);
    step();
    addr_ld = 0; cnt_ld = 0;
    m_addr = a; m_cnt = c;
    check_state(tag);
  endtask

  task automatic access(bit wr, logic [1:0] sz, logic [31:0] wd, string tag);
    int len, base;
    logic [31:0] exp;
    bit skip;
    len  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    base = (len > 1) ? (m_addr & ~1) : m_addr;
    skip = wr && (m_cnt == 0);
    exp  = 0;
    acc_req = 1; acc_wr = wr; acc_size = sz; acc_wdata = wd;
    step();
    acc_req = 0;
    if (!skip) begin
      for (int k = 0; k < len; k++) begin
        int a;
        a = (base + k) & 16'hFFFF;
        if (wr) begin
          if (win(a)) mdl[idx(a)] = wd[8*k +: 8];
        end else begin
          exp[8*k +: 8] = win(a) ? mdl[idx(a)] : 8'hFF;
        end
      end
      m_addr = (m_addr + len) & 16'hFFFF;
      if (m_addr == int'(ring_stop_pg) * 256) m_addr = int'(ring_start_pg) * 256;
      if (m_cnt <= len) begin m_cnt = 0; m_done = 1; end
      else m_cnt = m_cnt - len;
    end
    if (!wr) chk({tag, " rdata"}, acc_rdata, exp);
    chk({tag, " rvalid"}, 32'(acc_rvalid), wr ? 32'd0 : 32'd1);
    check_state(tag);
  endtask

  task automatic cmd(bit issue, bit clr, string tag);
    cmd_issue = issue; done_clr = clr;
    step();
    cmd_issue = 0; done_clr = 0;
    if (issue && m_cnt == 0) m_done = 1;
    else if (clr) m_done = 0;
    check_state(tag);
  endtask

  function automatic int pick_addr();
    case ($urandom % 5)
      0: return $urandom % 40;
      1: return 16376 + $urandom % 24;
      2: return 18424 + $urandom % 16;
      3: return 20472 + $urandom % 16;
      default: return 16384 + $urandom % 2048;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7919));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    chk("R1 rvalid", 32'(acc_rvalid), 32'd0);

    // fill both windows (ring pages 0 keep wrap out of the way)
    load(0, 16'hFFFF, "R2");
    for (int i = 0; i < LO / 4; i++) access(1, 2'b10, $urandom, "R4 fill");
    load(HB, 16'hFFFF, "R2");
    for (int i = 0; i < HS / 4; i++) access(1, 2'b11, $urandom, "R4 fill");

    ring_start_pg = 8'h40;
    ring_stop_pg  = 8'h48;
    @(negedge clk);

    // R4 little-endian, then narrow reads
    load(16400, 20, "R2");
    access(1, 2'b10, 32'hA1B2C3D4, "R4");
    load(16400, 20, "R2");
    access(0, 2'b00, 0, "R4");
    access(0, 2'b01, 0, "R3");
    // R3 odd address, multi-byte alignment
    load(16401, 20, "R2");
    access(0, 2'b01, 0, "R3");
    load(16403, 20, "R2");
    access(0, 2'b10, 0, "R3");
    // R6 straddle of low window and invalid write
    load(30, 20, "R2");
    access(0, 2'b10, 0, "R6");
    load(40, 20, "R2");
    access(1, 2'b10, 32'h12345678, "R6");
    load(40, 20, "R2");
    access(0, 2'b10, 0, "R6");
    load(20478, 20, "R2");
    access(0, 2'b10, 0, "R6");
    // R7 wrap at ring stop
    load(18430, 20, "R2");
    access(0, 2'b01, 0, "R7");
    chk("R7 wrapped", 32'(cur_addr), 32'd16384);
    // R8 final chunk shorter than access
    cmd(0, 1, "R11");
    load(16500, 3, "R2");
    access(0, 2'b10, 0, "R8");
    // R9 write ignored at count 0
    cmd(0, 1, "R11");
    access(1, 2'b10, 32'hDEADBEEF, "R9");
    load(16504, 4, "R2");
    access(0, 2'b10, 0, "R9");
    // R12 read at count 0
    cmd(0, 1, "R11");
    access(0, 2'b00, 0, "R12");
    // R10 command with zero and nonzero count
    cmd(0, 1, "R11");
    load(16600, 5, "R2");
    cmd(1, 0, "R10");
    load(16600, 0, "R2");
    cmd(1, 0, "R10");
    // R11 set wins over clear
    cmd(1, 1, "R11");
    cmd(0, 1, "R11");
    // R2 load beats same-cycle access
    load(16700, 10, "R2");
    addr_ld = 1; addr_ld_val = 16'd100;
    acc_req = 1; acc_wr = 0; acc_size = 2'b00;
    step();
    addr_ld = 0; acc_req = 0;
    m_addr = 100; m_cnt = 9;
    check_state("R2");
    // R5 no read data after a write
    access(1, 2'b00, 32'h5A, "R5");

    // constrained random
    for (int it = 0; it < 2500; it++) begin
      case ($urandom % 10)
        0: load(pick_addr(), $urandom % 24, "R2");
        1: cmd(1, 0, "R10");
        2: cmd(0, 1, "R11");
        3, 4: access(1, 2'($urandom), $urandom, "R6 R7 R8 R9");
        default: access(0, 2'($urandom), 0, "R4 R6 R7 R8 R12");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule